// File: doc/BRIEF.md
# Packed Byte and Word Media Execution Unit

This unit computes packed media operations on two 64-bit source operands. It supports five kinds of operation. It can widen bytes into 16-bit or 32-bit lanes. It can narrow 16-bit or 32-bit lanes down to bytes by dropping their upper bits. It can take the lane-wise minimum or maximum of 8-bit or 16-bit lanes, read as signed or unsigned. It can also form the sum of absolute byte differences that motion estimation needs. A 4-bit operation code chooses the operation. The unit has no internal state machine: each operation passes through combinational lane logic into one result register.

The caller presents `op_valid`, `op_code`, `src_a` and `src_b` together. On the next rising edge the result is captured and `res_valid` is raised for one cycle for each operation presented. A new operation can be accepted on every cycle. In a cycle with no operation, the previous result stays in the register.

Top module: `mv_media_simd`

## Requirements
- R1: During synchronous reset (`rst` high at a rising edge), `res` becomes 0 and `res_valid` becomes 0.
- R2: `res_valid` equals the `op_valid` of the previous cycle. `res` is loaded only on an edge where `op_valid` was high, and otherwise keeps its value.
- R3: Code 0 (widen bytes to 16 bits) sets each 16-bit lane i of the result, for i from 0 to 3, to byte i of `src_a` (bits 8i+7..8i) with zero extension.
- R4: Code 1 (widen bytes to 32 bits) sets each 32-bit lane i of the result, for i of 0 and 1, to byte i of `src_a` with zero extension.
- R5: Code 2 (narrow 16-bit lanes to bytes) sets result byte i, for i from 0 to 3, to bits 16i+7..16i of `src_a`. This is truncation. Result bits 63..32 are 0.
- R6: Code 3 (narrow 32-bit lanes to bytes) sets result byte i, for i of 0 and 1, to bits 32i+7..32i of `src_a`. Result bits 63..16 are 0.
- R7: Codes 4 to 7 give the lane-wise minimum of `src_a` and `src_b`. The four codes cover, in this order, unsigned 8-bit, unsigned 16-bit, signed 8-bit and signed 16-bit lanes. Signed lanes are read in two's complement.
- R8: Codes 8 to 11 give the lane-wise maximum. The lane kinds follow the same order as in R7.
- R9: Code 12 (pixel error) writes, into result bits 10..0, the sum over the eight byte pairs of the unsigned absolute difference between `src_a` and `src_b`. Bits 63..11 are 0, and the result never exceeds 2040.
- R10: Codes 13 to 15 are reserved. They produce an all-zero result with `res_valid` set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation select, with codes as listed in R3 to R10 |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| res | output | 64 | Registered result |
| res_valid | output | 1 | Result was loaded on the last edge |

## Verification
The clocked assertions check on every cycle that reset clears the register and that `res_valid` follows `op_valid` one cycle later. They also check that the result is held in idle cycles, that narrowing, pixel-error and reserved results have zeros in their unused upper bits, and that the pixel error stays within its range. Only the bench scenarios can show that the lane values themselves are correct. These are the zero extension when widening, truncation as opposed to saturation, the signed and unsigned ordering at the 0x80/0x7F boundary, and the exact sum of absolute differences, including its 2040 maximum. To show them, the bench compares each result with an independent model.

// File: rtl/mv_pkg.sv
package mv_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_WIDEN_W  = 4'd0,
        OP_WIDEN_L  = 4'd1,
        OP_NARROW_W = 4'd2,
        OP_NARROW_L = 4'd3,
        OP_MIN_U8   = 4'd4,
        OP_MIN_U16  = 4'd5,
        OP_MIN_S8   = 4'd6,
        OP_MIN_S16  = 4'd7,
        OP_MAX_U8   = 4'd8,
        OP_MAX_U16  = 4'd9,
        OP_MAX_S8   = 4'd10,
        OP_MAX_S16  = 4'd11,
        OP_PIXERR   = 4'd12,
        OP_RSV13    = 4'd13,
        OP_RSV14    = 4'd14,
        OP_RSV15    = 4'd15
    } mv_op_e;
endpackage

// File: rtl/mv_width_conv.sv
// Zero-extending widen and truncating narrow of packed lanes.
module mv_width_conv #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    output logic [DATA_W-1:0] widen_w,
    output logic [DATA_W-1:0] widen_l,
    output logic [DATA_W-1:0] narrow_w,
    output logic [DATA_W-1:0] narrow_l
);
    localparam int NW = DATA_W / 16;
    localparam int NL = DATA_W / 32;

    always_comb begin
        widen_w  = '0;
        widen_l  = '0;
        narrow_w = '0;
        narrow_l = '0;
        for (int i = 0; i < NW; i++) begin
            widen_w[16*i +: 16] = {8'h00, a[8*i +: 8]};
            narrow_w[8*i +: 8]  = a[16*i +: 8];
        end
        for (int i = 0; i < NL; i++) begin
            widen_l[32*i +: 32] = {24'h000000, a[8*i +: 8]};
            narrow_l[8*i +: 8]  = a[32*i +: 8];
        end
    end
endmodule

// File: rtl/mv_lane_minmax.sv
// Lane-wise min/max, signed or unsigned, for one lane width.
module mv_lane_minmax #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              is_signed,
    input  logic              is_max,
    output logic [DATA_W-1:0] y
);
    localparam int NLANE = DATA_W / LANE_W;

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        logic [LANE_W-1:0] xa, xb;
        logic              a_lt_b;
        assign xa     = a[i*LANE_W +: LANE_W];
        assign xb     = b[i*LANE_W +: LANE_W];
        assign a_lt_b = is_signed ? ($signed(xa) < $signed(xb)) : (xa < xb);
        assign y[i*LANE_W +: LANE_W] = (is_max ^ a_lt_b) ? xa : xb;
    end
endmodule

// File: rtl/mv_pixerr.sv
// Sum of absolute byte differences over all byte lanes.
module mv_pixerr #(
    parameter int DATA_W = 64,
    parameter int SUM_W  = $clog2((DATA_W / 8) * 255 + 1)
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [SUM_W-1:0]  sum
);
    localparam int NB = DATA_W / 8;

    logic [7:0] diff [NB];

    for (genvar i = 0; i < NB; i++) begin : g_abs
        logic [7:0] xa, xb;
        assign xa      = a[8*i +: 8];
        assign xb      = b[8*i +: 8];
        assign diff[i] = (xa >= xb) ? (xa - xb) : (xb - xa);
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < NB; i++) begin
            sum = sum + {{(SUM_W-8){1'b0}}, diff[i]};
        end
    end
endmodule

// File: rtl/mv_media_simd.sv
module mv_media_simd
    import mv_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] res,
    output logic              res_valid
);
    localparam int SUM_W = $clog2((DATA_W / 8) * 255 + 1);
    localparam int SUM_MAX = (DATA_W / 8) * 255;

    mv_op_e            op;
    logic [DATA_W-1:0] widen_w, widen_l, narrow_w, narrow_l;
    logic [DATA_W-1:0] mm8, mm16;
    logic [SUM_W-1:0]  pe_sum;
    logic              is_signed, is_max;
    logic [DATA_W-1:0] res_d;
    logic [DATA_W-1:0] res_q;
    logic              vld_q;

    assign op        = mv_op_e'(op_code);
    assign is_max    = op_code[3];
    assign is_signed = op_code[1];

    mv_width_conv #(.DATA_W(DATA_W)) u_conv (
        .a        (src_a),
        .widen_w  (widen_w),
        .widen_l  (widen_l),
        .narrow_w (narrow_w),
        .narrow_l (narrow_l)
    );

    mv_lane_minmax #(.DATA_W(DATA_W), .LANE_W(8)) u_mm8 (
        .a (src_a), .b (src_b), .is_signed (is_signed), .is_max (is_max), .y (mm8)
    );

    mv_lane_minmax #(.DATA_W(DATA_W), .LANE_W(16)) u_mm16 (
        .a (src_a), .b (src_b), .is_signed (is_signed), .is_max (is_max), .y (mm16)
    );

    mv_pixerr #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_pe (
        .a (src_a), .b (src_b), .sum (pe_sum)
    );

    // Result select
    always_comb begin
        unique case (op)
            OP_WIDEN_W:  res_d = widen_w;
            OP_WIDEN_L:  res_d = widen_l;
            OP_NARROW_W: res_d = narrow_w;
            OP_NARROW_L: res_d = narrow_l;
            OP_MIN_U8, OP_MIN_S8, OP_MAX_U8, OP_MAX_S8:     res_d = mm8;
            OP_MIN_U16, OP_MIN_S16, OP_MAX_U16, OP_MAX_S16: res_d = mm16;
            OP_PIXERR:   res_d = {{(DATA_W-SUM_W){1'b0}}, pe_sum};
            default:     res_d = '0;
        endcase
    end

    // Result register
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= op_valid;
            if (op_valid) begin
                res_q <= res_d;
            end
        end
    end

    assign res       = res_q;
    assign res_valid = vld_q;

    // Assertions
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (res == '0 && !res_valid));

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (res_valid == $past(op_valid)));

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(op_valid)) |-> $stable(res));

    assert_narrow_w_upper_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_valid) && $past(op_code) == OP_NARROW_W)
        |-> (res[DATA_W-1:32] == '0));

    assert_narrow_l_upper_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_valid) && $past(op_code) == OP_NARROW_L)
        |-> (res[DATA_W-1:16] == '0));

    assert_pixerr_range_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_valid) && $past(op_code) == OP_PIXERR)
        |-> (res[DATA_W-1:SUM_W] == '0 && res[SUM_W-1:0] <= SUM_W'(SUM_MAX)));

    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_valid) && $past(op_code) > OP_PIXERR)
        |-> (res == '0));
endmodule

// File: tb/mv_media_simd_bench.sv
module mv_media_simd_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 400;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [3:0]  op_code;
    logic [63:0] src_a, src_b;
    logic [63:0] res;
    logic        res_valid;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    mv_media_simd u_mv_media_simd (
        .clk (clk), .rst (rst), .op_valid (op_valid), .op_code (op_code),
        .src_a (src_a), .src_b (src_b), .res (res), .res_valid (res_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic string req_of(input logic [3:0] c);
        if (c == 4'd0) return "R3";
        if (c == 4'd1) return "R4";
        if (c == 4'd2) return "R5";
        if (c == 4'd3) return "R6";
        if (c <= 4'd7) return "R7";
        if (c <= 4'd11) return "R8";
        if (c == 4'd12) return "R9";
        return "R10";
    endfunction

    function automatic logic [63:0] model(input logic [3:0] c,
                                          input logic [63:0] a,
                                          input logic [63:0] b);
        logic [63:0] r = '0;
        int lw, n, sum;
        bit sgn, mx;
        case (c)
            4'd0: for (int i = 0; i < 4; i++) r[16*i +: 16] = 16'(a[8*i +: 8]);
            4'd1: for (int i = 0; i < 2; i++) r[32*i +: 32] = 32'(a[8*i +: 8]);
            4'd2: for (int i = 0; i < 4; i++) r[8*i +: 8] = a[16*i +: 8];
            4'd3: for (int i = 0; i < 2; i++) r[8*i +: 8] = a[32*i +: 8];
            4'd12: begin
                sum = 0;
                for (int i = 0; i < 8; i++) begin
                    int x, y;
                    x = int'(a[8*i +: 8]);
                    y = int'(b[8*i +: 8]);
                    sum += (x > y) ? x - y : y - x;
                end
                r = 64'(sum);
            end
            default: begin
                if (c >= 4'd4 && c <= 4'd11) begin
                    mx  = (c >= 4'd8);
                    sgn = (c == 4'd6 || c == 4'd7 || c == 4'd10 || c == 4'd11);
                    lw  = (c[0]) ? 16 : 8;
                    n   = 64 / lw;
                    for (int i = 0; i < n; i++) begin
                        longint x, y, pick;
                        if (lw == 8) begin
                            x = sgn ? longint'($signed(a[8*i +: 8])) : longint'(a[8*i +: 8]);
                            y = sgn ? longint'($signed(b[8*i +: 8])) : longint'(b[8*i +: 8]);
                        end else begin
                            x = sgn ? longint'($signed(a[16*i +: 16])) : longint'(a[16*i +: 16]);
                            y = sgn ? longint'($signed(b[16*i +: 16])) : longint'(b[16*i +: 16]);
                        end
                        pick = mx ? ((x > y) ? x : y) : ((x < y) ? x : y);
                        if (lw == 8) r[8*i +: 8] = pick[7:0];
                        else         r[16*i +: 16] = pick[15:0];
                    end
                end
            end
        endcase
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one operation, then check the registered result
    task automatic run_op(input logic [3:0] c, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        op_valid = 1'b1; op_code = c; src_a = a; src_b = b;
        @(posedge clk); #1;
        check(req_of(c), res, model(c, a, b));
        check("R2", 64'(res_valid), 64'd1);
    endtask

    initial begin
        logic [63:0] held;
        void'($urandom(32'd20240611));
        rst = 1'b1; op_valid = 1'b0; op_code = '0; src_a = '0; src_b = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", res, 64'd0);
        check("R1", 64'(res_valid), 64'd0);
        @(negedge clk); rst = 1'b0;

        // Directed corners
        run_op(4'd0, 64'hFFEE_DDCC_BBAA_9988, 64'd0);           // R3 zero extension
        run_op(4'd1, 64'h1122_3344_5566_80FF, 64'd0);           // R4
        run_op(4'd2, 64'h12FF_3480_56AB_7801, 64'd0);           // R5 truncation
        run_op(4'd3, 64'hDEAD_BEEF_CAFE_F00D, 64'd0);           // R6
        run_op(4'd4, 64'h807F_0001_FF00_1234, 64'h7F80_0100_00FF_3412); // R7 unsigned
        run_op(4'd6, 64'h807F_0001_FF00_1234, 64'h7F80_0100_00FF_3412); // R7 signed
        run_op(4'd7, 64'h8000_7FFF_FFFF_0001, 64'h7FFF_8000_0001_FFFF); // R7 s16
        run_op(4'd9, 64'h8000_7FFF_FFFF_0001, 64'h7FFF_8000_0001_FFFF); // R8 u16
        run_op(4'd10, 64'h807F_0001_FF00_1234, 64'h7F80_0100_00FF_3412); // R8 s8
        run_op(4'd12, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF); // R9 max 2040
        run_op(4'd12, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF); // R9 zero
        run_op(4'd13, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);           // R10
        run_op(4'd15, 64'h5555_AAAA_5555_AAAA, 64'h3);           // R10

        // R2: idle cycle holds result and drops valid
        held = res;
        @(negedge clk);
        op_valid = 1'b0; op_code = 4'd12; src_a = '1; src_b = '0;
        @(posedge clk); #1;
        check("R2", res, held);
        check("R2", 64'(res_valid), 64'd0);

        // Random stimulus
        for (int k = 0; k < N_RANDOM; k++) begin
            logic [63:0] a, b;
            logic [3:0]  c;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            c = 4'($urandom_range(0, 15));
            run_op(c, a, b);
        end

        // R1: reset mid-stream clears result
        @(negedge clk); op_valid = 1'b1; rst = 1'b1;
        @(posedge clk); #1;
        check("R1", res, 64'd0);
        check("R1", 64'(res_valid), 64'd0);
        @(negedge clk); rst = 1'b0; op_valid = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule